// File: doc/BRIEF.md
# Port I/O Instruction Sequencer

This block executes the port input and output instructions of an 8-bit accumulator-style processor core. The core hands it an opcode that has already been fetched, either one byte plus an immediate port byte, or a prefix byte plus a second byte. It also supplies the current register values. The sequencer then steps through the machine cycles of that instruction one T-state per clock. It performs the I/O and memory transfers on two separate request/acknowledge buses. In the final T-state it presents register, pointer, counter and flag write-backs for the core to commit.

Each T-state lasts one clock. The first machine cycle of every instruction is an internal cycle, and so is the second (the opcode bytes are already in hand). Only the later machine cycles use a bus. A bus machine cycle raises its request in its first T-state. Its last T-state repeats as a wait state until the transfer completes. Writes complete on the acknowledge. Reads complete on the one-cycle read-valid strobe, which carries the data.

Top module: `io_seq`

## Requirements
- R1: After reset, and whenever no instruction is running, `busy`, `done`, `io_req` and `mem_req` are low and `m_cyc`/`t_st` read 0.
- R2: Opcode 0xDB with immediate n reads the I/O port at address {A, n} and writes the byte to the accumulator (`wb_idx` = 3'b111) with no flag write. It takes 4/3/4 T-states in three machine cycles, and the read happens in the third.
- R3: Prefix 0xED with second byte 01 fff 000 reads the port at address {B, C} and writes the byte to register fff (`wb_idx` = fff). It takes 4/4/4 T-states, and the read happens in the third machine cycle.
- R4: For that register input, `f_out` has bit7 = byte bit 7, bit6 = (byte == 0), bit4 = 0, bit2 = 1 when the byte has an even count of ones, and bit1 = 0. Bits 5, 3 and 0 copy `f_in`, and `f_we` is high.
- R5: When fff is 110 in the register input form, `wb_we` stays low and only the flags are written.
- R6: 0xED with 01 fff 001 (fff ≠ 110) writes `r_in` to port {B, C} in the third machine cycle of a 4/4/4 sequence, with no register or flag write.
- R7: 0xED 0xA2 reads port {B, C} in machine cycle 3 and writes that byte to memory at HL in machine cycle 4. It returns HL+1 and B−1, with timing 4/5/3/4.
- R8: 0xED 0xA3 reads memory at HL in machine cycle 3 and writes that byte to port {B, C} in machine cycle 4, using B before the decrement. It returns HL+1 and B−1, with timing 4/5/3/4.
- R9: 0xED 0xAA behaves as R7 except that HL is returned as HL−1, wrapping 0x0000 to 0xFFFF. B wraps 0x00 to 0xFF.
- R10: For the three block transfers, `f_out` bit6 = (B−1 == 0) and bit1 = 1, and all other bits copy `f_in`.
- R11: A bus request stays high until its transfer completes, and only one bus requests at a time. The last T-state of a bus machine cycle repeats while the transfer is outstanding.
- R12: Any other opcode, including 0xED 01 110 001, completes after two internal 4-T-state machine cycles with `err` high, no bus request and no write enable.
- R13: A `start` pulse while `busy` is high is ignored and does not alter the running instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| op0_in | input | DW | First opcode byte |
| op1_in | input | DW | Second byte or immediate port byte |
| r_sel | output | 3 | Register field op1_in[5:3], for the core's register mux |
| a_in | input | DW | Accumulator |
| b_in | input | DW | Register B |
| c_in | input | DW | Register C |
| h_in | input | DW | Register H |
| l_in | input | DW | Register L |
| r_in | input | DW | Register selected by r_sel |
| f_in | input | 8 | Flag register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final T-state; write-backs valid |
| err | output | 1 | Illegal opcode, valid with done |
| m_cyc | output | 3 | Current machine cycle (1-based) |
| t_st | output | 3 | Current T-state (1-based) |
| io_req | output | 1 | I/O transfer request |
| io_we | output | 1 | I/O direction, 1 = write |
| io_addr | output | 2*DW | I/O port address |
| io_wdata | output | DW | I/O write data |
| io_ack | input | 1 | I/O write acknowledge |
| io_rvalid | input | 1 | I/O read data valid strobe |
| io_rdata | input | DW | I/O read data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory direction, 1 = write |
| mem_addr | output | 2*DW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |
| mem_rvalid | input | 1 | Memory read data valid strobe |
| mem_rdata | input | DW | Memory read data |
| wb_we | output | 1 | Register write enable |
| wb_idx | output | 3 | Register index to write |
| wb_data | output | DW | Register write data |
| b_we | output | 1 | Counter B write enable |
| b_out | output | DW | New B |
| hl_we | output | 1 | HL write enable |
| hl_out | output | 2*DW | New HL |
| f_we | output | 1 | Flag write enable |
| f_out | output | 8 | New flags |

## Verification
Each instruction form is tried with responder latencies that finish inside the bus machine cycle, and with latencies that force one or more wait states. This separates the fixed T-state schedule from the stretching rule. The register input is fed a negative byte, zero, an even-parity byte and an odd-parity byte, so that every computed flag bit is shown to move on its own. The block transfers are run with B = 1, with B = 0 and with HL at 0x12FF and 0x0000, which exposes the zero flag, the counter wrap and the carry across the pointer halves. Illegal second bytes, a flags-only destination and a start pulse injected mid-instruction show that nothing unintended is written or started.

// File: rtl/io_seq_pkg.sv
// Shared opcode constants, kinds and per-instruction schedule tables for the
// port I/O sequencer. Assumes 8-bit opcodes; schedules are computed, not stored.
package io_seq_pkg;

    localparam logic [7:0] OPC_IN_IMM = 8'hDB;
    localparam logic [7:0] OPC_PREFIX = 8'hED;
    localparam logic [7:0] OPC_BLK_IN_UP = 8'hA2;
    localparam logic [7:0] OPC_BLK_OUT_UP = 8'hA3;
    localparam logic [7:0] OPC_BLK_IN_DN = 8'hAA;
    localparam logic [2:0] FLD_NONE = 3'b110;
    localparam logic [2:0] FLD_ACC = 3'b111;
    localparam int FLAG_W = 8;

    typedef enum logic [2:0] {
        K_IN_IMM, K_IN_REG, K_OUT_REG, K_BIN_UP, K_BOUT_UP, K_BIN_DN, K_ILLEGAL
    } op_kind_t;

    typedef enum logic [2:0] {
        BC_NONE, BC_IORD, BC_IOWR, BC_MRD, BC_MWR
    } bus_kind_t;

    // Classify the two opcode bytes into an instruction kind.
    function automatic op_kind_t classify(input logic [7:0] b0, input logic [7:0] b1);
        op_kind_t k;
        k = K_ILLEGAL;
        if (b0 == OPC_IN_IMM) begin
            k = K_IN_IMM;
        end else if (b0 == OPC_PREFIX) begin
            if (b1[7:6] == 2'b01 && b1[2:0] == 3'b000)
                k = K_IN_REG;
            else if (b1[7:6] == 2'b01 && b1[2:0] == 3'b001 && b1[5:3] != FLD_NONE)
                k = K_OUT_REG;
            else if (b1 == OPC_BLK_IN_UP)
                k = K_BIN_UP;
            else if (b1 == OPC_BLK_OUT_UP)
                k = K_BOUT_UP;
            else if (b1 == OPC_BLK_IN_DN)
                k = K_BIN_DN;
        end
        return k;
    endfunction

    // T-states in machine cycle m of kind k.
    function automatic logic [2:0] mc_len(input op_kind_t k, input logic [2:0] m);
        logic [2:0] n;
        n = 3'd4;
        case (k)
            K_IN_IMM: if (m == 3'd2) n = 3'd3;
            K_BIN_UP, K_BOUT_UP, K_BIN_DN: begin
                if (m == 3'd2) n = 3'd5;
                else if (m == 3'd3) n = 3'd3;
            end
            default: n = 3'd4;
        endcase
        return n;
    endfunction

    // Number of machine cycles of kind k.
    function automatic logic [2:0] mc_count(input op_kind_t k);
        logic [2:0] n;
        case (k)
            K_BIN_UP, K_BOUT_UP, K_BIN_DN: n = 3'd4;
            K_ILLEGAL: n = 3'd2;
            default: n = 3'd3;
        endcase
        return n;
    endfunction

    // Bus transfer performed in machine cycle m of kind k.
    function automatic bus_kind_t mc_bus(input op_kind_t k, input logic [2:0] m);
        bus_kind_t b;
        b = BC_NONE;
        case (k)
            K_IN_IMM, K_IN_REG: if (m == 3'd3) b = BC_IORD;
            K_OUT_REG: if (m == 3'd3) b = BC_IOWR;
            K_BIN_UP, K_BIN_DN: begin
                if (m == 3'd3) b = BC_IORD;
                else if (m == 3'd4) b = BC_MWR;
            end
            K_BOUT_UP: begin
                if (m == 3'd3) b = BC_MRD;
                else if (m == 3'd4) b = BC_IOWR;
            end
            default: b = BC_NONE;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/io_seq_timer.sv
// Machine-cycle / T-state counter. Steps one T-state per clock, holds the last
// T-state of a bus machine cycle until the transfer completes.
// Assumes kind is stable from the cycle after go until fin.
module io_seq_timer
    import io_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  op_kind_t   kind,
    input  logic       complete,
    output logic       busy,
    output logic [2:0] m_cyc,
    output logic [2:0] t_st,
    output logic       fin,
    output logic       step
);
    logic at_end;
    logic may_leave;
    logic last_m;

    // End-of-machine-cycle decisions for the current T-state.
    always_comb begin
        at_end    = (t_st == mc_len(kind, m_cyc));
        may_leave = (mc_bus(kind, m_cyc) == BC_NONE) || complete;
        last_m    = (m_cyc == mc_count(kind));
        fin       = busy && at_end && may_leave && last_m;
        step      = busy && at_end && may_leave;
    end

    // Counter state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            m_cyc <= 3'd0;
            t_st  <= 3'd0;
        end else if (go) begin
            busy  <= 1'b1;
            m_cyc <= 3'd1;
            t_st  <= 3'd1;
        end else if (fin) begin
            busy  <= 1'b0;
            m_cyc <= 3'd0;
            t_st  <= 3'd0;
        end else if (step) begin
            m_cyc <= m_cyc + 3'd1;
            t_st  <= 3'd1;
        end else if (busy && !at_end) begin
            t_st <= t_st + 3'd1;
        end
    end
endmodule

// File: rtl/io_seq_bus.sv
// Bus handshake tracker for the I/O and memory buses. Raises the request of the
// current machine cycle until it completes (ack for writes, rvalid for reads)
// and captures read data. Assumes one transfer per machine cycle.
module io_seq_bus
    import io_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  bus_kind_t     bc,
    input  logic          io_ack,
    input  logic          io_rvalid,
    input  logic [DW-1:0] io_rdata,
    input  logic          mem_ack,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          io_req,
    output logic          io_we,
    output logic          mem_req,
    output logic          mem_we,
    output logic          complete,
    output logic [DW-1:0] rd_byte
);
    logic          got_r;
    logic          hit;
    logic          is_rd;
    logic [DW-1:0] data_r;
    logic [DW-1:0] rd_src;

    // Request generation and completion detection.
    always_comb begin
        io_we    = (bc == BC_IOWR);
        mem_we   = (bc == BC_MWR);
        io_req   = !got_r && (bc == BC_IORD || bc == BC_IOWR);
        mem_req  = !got_r && (bc == BC_MRD || bc == BC_MWR);
        hit      = (io_req && (io_we ? io_ack : io_rvalid)) ||
                   (mem_req && (mem_we ? mem_ack : mem_rvalid));
        is_rd    = (bc == BC_IORD) || (bc == BC_MRD);
        rd_src   = (bc == BC_IORD) ? io_rdata : mem_rdata;
        complete = got_r || hit;
        rd_byte  = (hit && is_rd) ? rd_src : data_r;
    end

    // Per-machine-cycle completion flag and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_r  <= 1'b0;
            data_r <= '0;
        end else begin
            if (clear) got_r <= 1'b0;
            else if (hit) got_r <= 1'b1;
            if (hit && is_rd) data_r <= rd_src;
        end
    end
endmodule

// File: rtl/io_seq_wb.sv
// Write-back and flag computation from the latched instruction and the
// transferred byte. Purely combinational; the top gates it with done.
module io_seq_wb
    import io_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_kind_t            kind,
    input  logic [2:0]          fld,
    input  logic [DW-1:0]       data,
    input  logic [DW-1:0]       b_val,
    input  logic [2*DW-1:0]     hl_val,
    input  logic [FLAG_W-1:0]   f_val,
    output logic                wb_we,
    output logic [2:0]          wb_idx,
    output logic [DW-1:0]       wb_data,
    output logic                b_we,
    output logic [DW-1:0]       b_out,
    output logic                hl_we,
    output logic [2*DW-1:0]     hl_out,
    output logic                f_we,
    output logic [FLAG_W-1:0]   f_out
);
    logic          blk;
    logic [DW-1:0] b_dec;

    // Select destinations, pointer/counter updates and flags per kind.
    always_comb begin
        blk     = (kind == K_BIN_UP) || (kind == K_BOUT_UP) || (kind == K_BIN_DN);
        b_dec   = b_val - 1'b1;
        wb_data = data;
        wb_idx  = (kind == K_IN_IMM) ? FLD_ACC : fld;
        wb_we   = (kind == K_IN_IMM) || (kind == K_IN_REG && fld != FLD_NONE);
        b_we    = blk;
        b_out   = b_dec;
        hl_we   = blk;
        hl_out  = (kind == K_BIN_DN) ? hl_val - 1'b1 : hl_val + 1'b1;
        f_we    = blk || (kind == K_IN_REG);
        if (blk)
            f_out = {f_val[7], (b_dec == '0), f_val[5:2], 1'b1, f_val[0]};
        else
            f_out = {data[DW-1], (data == '0), f_val[5], 1'b0, f_val[3], ~^data, 1'b0, f_val[0]};
    end
endmodule

// File: rtl/io_seq.sv
// Top of the port I/O instruction sequencer. Latches the opcode and register
// values on start, sequences machine cycles, drives both buses and presents
// write-backs in the final T-state. Assumes inputs valid in the start cycle.
module io_seq
    import io_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DW-1:0]   op0_in,
    input  logic [DW-1:0]   op1_in,
    output logic [2:0]      r_sel,
    input  logic [DW-1:0]   a_in,
    input  logic [DW-1:0]   b_in,
    input  logic [DW-1:0]   c_in,
    input  logic [DW-1:0]   h_in,
    input  logic [DW-1:0]   l_in,
    input  logic [DW-1:0]   r_in,
    input  logic [7:0]      f_in,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [2:0]      m_cyc,
    output logic [2:0]      t_st,
    output logic            io_req,
    output logic            io_we,
    output logic [2*DW-1:0] io_addr,
    output logic [DW-1:0]   io_wdata,
    input  logic            io_ack,
    input  logic            io_rvalid,
    input  logic [DW-1:0]   io_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [2*DW-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic            mem_rvalid,
    input  logic [DW-1:0]   mem_rdata,
    output logic            wb_we,
    output logic [2:0]      wb_idx,
    output logic [DW-1:0]   wb_data,
    output logic            b_we,
    output logic [DW-1:0]   b_out,
    output logic            hl_we,
    output logic [2*DW-1:0] hl_out,
    output logic            f_we,
    output logic [7:0]      f_out
);
    localparam int AW = 2 * DW;

    op_kind_t      kind_r;
    logic [DW-1:0] op1_r, a_r, b_r, c_r, h_r, l_r, r_r;
    logic [7:0]    f_r;
    logic          go, step, complete, legal;
    bus_kind_t     bc;
    logic [DW-1:0] rd_byte;
    logic          wb_we_i, b_we_i, hl_we_i, f_we_i;

    assign go    = start && !busy;
    assign r_sel = op1_in[5:3];

    // Capture the instruction and register snapshot when an instruction starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_r <= K_ILLEGAL;
            op1_r  <= '0;
            a_r <= '0; b_r <= '0; c_r <= '0; h_r <= '0; l_r <= '0; r_r <= '0;
            f_r    <= '0;
        end else if (go) begin
            kind_r <= classify(8'(op0_in), 8'(op1_in));
            op1_r  <= op1_in;
            a_r <= a_in; b_r <= b_in; c_r <= c_in; h_r <= h_in; l_r <= l_in; r_r <= r_in;
            f_r    <= f_in;
        end
    end

    io_seq_timer u_tmr (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(kind_r), .complete(complete),
        .busy(busy), .m_cyc(m_cyc), .t_st(t_st), .fin(done), .step(step)
    );

    // Bus kind of the current machine cycle (none when idle).
    always_comb bc = busy ? mc_bus(kind_r, m_cyc) : BC_NONE;

    io_seq_bus #(.DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n), .clear(go || step), .bc(bc),
        .io_ack(io_ack), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .io_req(io_req), .io_we(io_we), .mem_req(mem_req), .mem_we(mem_we),
        .complete(complete), .rd_byte(rd_byte)
    );

    // Address and write-data routing.
    always_comb begin
        io_addr   = (kind_r == K_IN_IMM) ? {a_r, op1_r} : {b_r, c_r};
        io_wdata  = (kind_r == K_BOUT_UP) ? rd_byte : r_r;
        mem_addr  = {h_r, l_r};
        mem_wdata = rd_byte;
    end

    io_seq_wb #(.DW(DW)) u_wb (
        .kind(kind_r), .fld(op1_r[5:3]), .data(rd_byte), .b_val(b_r),
        .hl_val({h_r, l_r}), .f_val(f_r),
        .wb_we(wb_we_i), .wb_idx(wb_idx), .wb_data(wb_data),
        .b_we(b_we_i), .b_out(b_out), .hl_we(hl_we_i), .hl_out(hl_out),
        .f_we(f_we_i), .f_out(f_out)
    );

    // Commit strobes only in the final T-state of a legal instruction.
    always_comb begin
        legal = (kind_r != K_ILLEGAL);
        err   = done && !legal;
        wb_we = done && legal && wb_we_i;
        b_we  = done && legal && b_we_i;
        hl_we = done && legal && hl_we_i;
        f_we  = done && legal && f_we_i;
    end

    logic unused_ok;
    assign unused_ok = ^{AW[0]};
endmodule

// File: rtl/io_seq_chk.sv
// Protocol and sequencing checks for io_seq, attached by bind.
module io_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [2:0] m_cyc,
    input logic [2:0] t_st,
    input logic       io_req,
    input logic       io_we,
    input logic       io_ack,
    input logic       io_rvalid,
    input logic       mem_req,
    input logic       mem_we,
    input logic       mem_ack,
    input logic       mem_rvalid,
    input logic       wb_we,
    input logic       b_we,
    input logic       hl_we,
    input logic       f_we
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!io_req && !mem_req && !done && m_cyc == 3'd0 && t_st == 3'd0));

    assert_done_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_one_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_req && mem_req));

    assert_io_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !(io_we ? io_ack : io_rvalid)) |=> io_req);

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !(mem_we ? mem_ack : mem_rvalid)) |=> mem_req);

    assert_t_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (t_st >= 3'd1 && t_st <= 3'd5 && m_cyc >= 3'd1 && m_cyc <= 3'd4));

    assert_err_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !wb_we && !b_we && !hl_we && !f_we));

    assert_busy_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);
endmodule

bind io_seq io_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
    .m_cyc(m_cyc), .t_st(t_st), .io_req(io_req), .io_we(io_we), .io_ack(io_ack),
    .io_rvalid(io_rvalid), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_rvalid(mem_rvalid), .wb_we(wb_we), .b_we(b_we), .hl_we(hl_we), .f_we(f_we)
);

// File: tb/tb_io_seq.sv
`timescale 1ns/1ps
module tb_io_seq;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, start;
    logic [7:0]  op0_in, op1_in, a_in, b_in, c_in, h_in, l_in, r_in, f_in;
    logic [2:0]  r_sel;
    logic        busy, done, err;
    logic [2:0]  m_cyc, t_st;
    logic        io_req, io_we, io_ack, io_rvalid;
    logic [15:0] io_addr, mem_addr, hl_out;
    logic [7:0]  io_wdata, io_rdata, mem_wdata, mem_rdata;
    logic        mem_req, mem_we, mem_ack, mem_rvalid;
    logic        wb_we, b_we, hl_we, f_we;
    logic [2:0]  wb_idx;
    logic [7:0]  wb_data, b_out, f_out;

    io_seq dut (.*);

    int checks = 0;
    int errors = 0;
    int lat_g = 1;
    logic [7:0] iov_g = 8'h00;
    logic [7:0] memv_g = 8'h00;
    int tq_type[$];
    int tq_addr[$];
    int tq_data[$];
    string tag_g = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bus responder: answers a request after lat_g cycles, checks each transfer.
    initial begin
        int cnt;
        int ty;
        cnt = 0;
        io_ack = 0; io_rvalid = 0; io_rdata = 0;
        mem_ack = 0; mem_rvalid = 0; mem_rdata = 0;
        forever begin
            @(negedge clk);
            if (io_ack || io_rvalid || mem_ack || mem_rvalid) begin
                io_ack = 0; io_rvalid = 0; mem_ack = 0; mem_rvalid = 0;
            end
            if (io_req || mem_req) begin
                cnt++;
                if (cnt >= lat_g) begin
                    cnt = 0;
                    ty = io_req ? (io_we ? 2 : 1) : (mem_we ? 4 : 3);
                    if (tq_type.size() == 0) begin
                        chk(0, tag_g, "unexpected bus transfer", ty, 0);
                    end else begin
                        int et, ea, ed;
                        et = tq_type.pop_front();
                        ea = tq_addr.pop_front();
                        ed = tq_data.pop_front();
                        chk(ty == et, tag_g, "bus kind", ty, et);
                        chk(int'(io_req ? io_addr : mem_addr) == ea, tag_g, "bus address",
                            int'(io_req ? io_addr : mem_addr), ea);
                        if (ty == 2) chk(int'(io_wdata) == ed, tag_g, "io write data", io_wdata, ed);
                        if (ty == 4) chk(int'(mem_wdata) == ed, tag_g, "mem write data", mem_wdata, ed);
                    end
                    if (ty == 1) begin io_ack = 1; io_rvalid = 1; io_rdata = iov_g; end
                    if (ty == 2) io_ack = 1;
                    if (ty == 3) begin mem_ack = 1; mem_rvalid = 1; mem_rdata = memv_g; end
                    if (ty == 4) mem_ack = 1;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // Reference model: builds the expected T-state trace, bus transfers and
    // write-backs from the requirements, then compares on every clock.
    task automatic run_op(input string tag, input logic [7:0] o0, input logic [7:0] o1,
                          input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                          input logic [7:0] h, input logic [7:0] l, input logic [7:0] r,
                          input logic [7:0] f, input int lat, input logic [7:0] iov,
                          input logic [7:0] memv, input bit poke);
        int k, nm;
        int lens[5];
        int bt[5];
        int cq[$];
        bit e_err, e_wbwe, e_bwe, e_hlwe, e_fwe;
        int e_idx, e_wbd, e_b, e_hl, e_f;
        logic [7:0] bm1;
        logic [2:0] fld;
        fld = o1[5:3];
        bm1 = b - 8'd1;
        k = 6;
        if (o0 == 8'hDB) k = 0;
        else if (o0 == 8'hED) begin
            if (o1[7:6] == 2'b01 && o1[2:0] == 3'b000) k = 1;
            else if (o1[7:6] == 2'b01 && o1[2:0] == 3'b001 && fld != 3'b110) k = 2;
            else if (o1 == 8'hA2) k = 3;
            else if (o1 == 8'hA3) k = 4;
            else if (o1 == 8'hAA) k = 5;
        end
        for (int i = 0; i < 5; i++) begin lens[i] = 4; bt[i] = 0; end
        e_err = 0; e_wbwe = 0; e_bwe = 0; e_hlwe = 0; e_fwe = 0;
        e_idx = 0; e_wbd = 0; e_b = 0; e_hl = 0; e_f = 0;
        nm = 3;
        case (k)
            0: begin lens[2] = 3; bt[3] = 1;
                tq_type.push_back(1); tq_addr.push_back({a, o1}); tq_data.push_back(0);
                e_wbwe = 1; e_idx = 7; e_wbd = iov; end
            1: begin bt[3] = 1;
                tq_type.push_back(1); tq_addr.push_back({b, c}); tq_data.push_back(0);
                e_wbwe = (fld != 3'b110); e_idx = fld; e_wbd = iov; e_fwe = 1;
                e_f = {iov[7], iov == 8'h00, f[5], 1'b0, f[3], ~^iov, 1'b0, f[0]}; end
            2: begin bt[3] = 2;
                tq_type.push_back(2); tq_addr.push_back({b, c}); tq_data.push_back(r); end
            3, 4, 5: begin nm = 4; lens[2] = 5; lens[3] = 3;
                if (k == 4) begin
                    bt[3] = 3; bt[4] = 2;
                    tq_type.push_back(3); tq_addr.push_back({h, l}); tq_data.push_back(0);
                    tq_type.push_back(2); tq_addr.push_back({b, c}); tq_data.push_back(memv);
                end else begin
                    bt[3] = 1; bt[4] = 4;
                    tq_type.push_back(1); tq_addr.push_back({b, c}); tq_data.push_back(0);
                    tq_type.push_back(4); tq_addr.push_back({h, l}); tq_data.push_back(iov);
                end
                e_bwe = 1; e_b = bm1; e_hlwe = 1; e_fwe = 1;
                e_hl = (k == 5) ? ((({h, l}) - 1) & 16'hFFFF) : ((({h, l}) + 1) & 16'hFFFF);
                e_f = {f[7], bm1 == 8'h00, f[5:2], 1'b1, f[0]}; end
            default: begin nm = 2; e_err = 1; end
        endcase
        for (int m = 1; m <= nm; m++) begin
            for (int t = 1; t <= lens[m]; t++) cq.push_back(m * 8 + t);
            if (bt[m] != 0 && lat > lens[m])
                for (int w = 0; w < lat - lens[m]; w++) cq.push_back(m * 8 + lens[m]);
        end
        tag_g = tag; lat_g = lat; iov_g = iov; memv_g = memv;
        @(negedge clk); #2;
        op0_in = o0; op1_in = o1; a_in = a; b_in = b; c_in = c;
        h_in = h; l_in = l; r_in = r; f_in = f; start = 1;
        @(negedge clk); #2;
        start = 0;
        for (int i = 0; i < cq.size(); i++) begin
            bit last;
            last = (i == cq.size() - 1);
            chk(busy == 1'b1, tag, "busy", busy, 1);
            chk({m_cyc, t_st} == 6'(cq[i]), tag, "machine cycle/T-state",
                {m_cyc, t_st}, cq[i]);
            chk(done == last, tag, "done", done, last);
            if (last) begin
                chk(err == e_err, tag, "err", err, e_err);
                chk(wb_we == e_wbwe, tag, "wb_we", wb_we, e_wbwe);
                if (e_wbwe) begin
                    chk(wb_idx == 3'(e_idx), tag, "wb_idx", wb_idx, e_idx);
                    chk(wb_data == 8'(e_wbd), tag, "wb_data", wb_data, e_wbd);
                end
                chk(b_we == e_bwe, tag, "b_we", b_we, e_bwe);
                if (e_bwe) chk(b_out == 8'(e_b), tag, "b_out", b_out, e_b);
                chk(hl_we == e_hlwe, tag, "hl_we", hl_we, e_hlwe);
                if (e_hlwe) chk(hl_out == 16'(e_hl), tag, "hl_out", hl_out, e_hl);
                chk(f_we == e_fwe, tag, "f_we", f_we, e_fwe);
                if (e_fwe) chk(f_out == 8'(e_f), tag, "f_out", f_out, e_f);
            end
            // R13: a second start in mid-instruction must be ignored.
            if (poke && i == 2) begin start = 1; op0_in = 8'hDB; op1_in = 8'h00; end
            if (poke && i == 3) start = 0;
            @(negedge clk); #2;
        end
        chk(busy == 1'b0, tag, "idle after done", busy, 0);
        chk(tq_type.size() == 0, tag, "missing bus transfers", tq_type.size(), 0);
        tq_type.delete(); tq_addr.delete(); tq_data.delete();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; start = 0;
        op0_in = 0; op1_in = 0; a_in = 0; b_in = 0; c_in = 0;
        h_in = 0; l_in = 0; r_in = 0; f_in = 0;
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        @(negedge clk); #2;
        chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
        chk(io_req == 0 && mem_req == 0, "R1", "requests after reset", {io_req, mem_req}, 0);
        chk(m_cyc == 0 && t_st == 0, "R1", "counters after reset", {m_cyc, t_st}, 0);

        run_op("R2", 8'hDB, 8'h34, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC5, 1, 8'h5A, 8'h00, 0);
        run_op("R11", 8'hDB, 8'hF0, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 6, 8'h77, 8'h00, 0);
        run_op("R3", 8'hED, 8'h40, 8'h00, 8'h9A, 8'hBC, 8'h00, 8'h00, 8'h00, 8'h00, 2, 8'h80, 8'h00, 0);
        run_op("R4", 8'hED, 8'h78, 8'h00, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'hFF, 1, 8'h00, 8'h00, 0);
        run_op("R4", 8'hED, 8'h50, 8'h00, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 8'h28, 3, 8'h03, 8'h00, 0);
        run_op("R4", 8'hED, 8'h58, 8'h00, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 8'hD7, 4, 8'h01, 8'h00, 0);
        run_op("R5", 8'hED, 8'h70, 8'h00, 8'h44, 8'h55, 8'h00, 8'h00, 8'h00, 8'h01, 1, 8'hFE, 8'h00, 0);
        run_op("R6", 8'hED, 8'h59, 8'h00, 8'h3C, 8'h4D, 8'h00, 8'h00, 8'hC3, 8'h00, 3, 8'h00, 8'h00, 0);
        run_op("R11", 8'hED, 8'h79, 8'h00, 8'h3C, 8'h4D, 8'h00, 8'h00, 8'h96, 8'h00, 7, 8'h00, 8'h00, 0);
        run_op("R7", 8'hED, 8'hA2, 8'h00, 8'h01, 8'h10, 8'h12, 8'hFF, 8'h00, 8'h00, 1, 8'h6B, 8'h00, 0);
        run_op("R10", 8'hED, 8'hA2, 8'h00, 8'h05, 8'h10, 8'h40, 8'h00, 8'h00, 8'hFD, 2, 8'h11, 8'h00, 0);
        run_op("R8", 8'hED, 8'hA3, 8'h00, 8'h05, 8'h7E, 8'h20, 8'h30, 8'h00, 8'h41, 4, 8'h00, 8'hE1, 0);
        run_op("R9", 8'hED, 8'hAA, 8'h00, 8'h00, 8'h99, 8'h00, 8'h00, 8'h00, 8'h00, 1, 8'h2D, 8'h00, 0);
        run_op("R11", 8'hED, 8'hAA, 8'h00, 8'h02, 8'h99, 8'h80, 8'h00, 8'h00, 8'h00, 6, 8'h3E, 8'h00, 0);
        run_op("R12", 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 1, 8'h00, 8'h00, 0);
        run_op("R12", 8'hED, 8'h45, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 1, 8'h00, 8'h00, 0);
        run_op("R12", 8'hED, 8'h71, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 1, 8'h00, 8'h00, 0);
        run_op("R13", 8'hED, 8'h48, 8'h00, 8'h0A, 8'h0B, 8'h00, 8'h00, 8'h00, 8'h00, 2, 8'h81, 8'h00, 1);

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule